// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is the purely combinational arithmetic stage of a small accumulator datapath. It takes the accumulator operand, a second operand from a buffer register and a four-bit function code. In the same cycle it returns a result word together with a sign flag and a zero flag. The datapath around it stores the result, so the unit keeps no state.

Add, subtract, AND and OR use both operands. Inversion uses only the buffer operand. The two one-bit logical shifts use only the accumulator operand. Multiply returns the low half of the product. Divide returns the unsigned quotient rounded toward zero. Any code that names no function returns the accumulator unchanged, so an idle control word cannot disturb the accumulator.

The width is a parameter. Multiply and divide each have two build variants: the native operator, or an unrolled shift-add or restoring array. Both variants produce the same results.

Top module: `acc_alu`

## Requirements
- R1: Code 0001 gives the accumulator operand plus the buffer operand, keeping the low DATA_W bits so that the sum wraps.
- R2: Code 0010 gives the accumulator operand minus the buffer operand, modulo 2^DATA_W.
- R3: Code 0011 gives the bitwise AND of the two operands. Code 0100 gives their bitwise OR.
- R4: Code 0101 gives the bitwise inverse of the buffer operand. The accumulator operand has no effect on the result.
- R5: Code 0110 shifts the accumulator operand right by one bit and fills the top bit with zero. The buffer operand has no effect.
- R6: Code 0111 shifts the accumulator operand left by one bit and fills bit 0 with zero. The buffer operand has no effect.
- R7: Code 1000 gives the low DATA_W bits of the unsigned product of the two operands.
- R8: Code 1001 gives the unsigned quotient of the accumulator operand divided by the buffer operand, rounded toward zero.
- R9: Under code 1001, a buffer operand of zero gives a result of all ones.
- R10: Code 0000 and codes 1010 through 1111 return the accumulator operand unchanged.
- R11: The sign flag equals the most significant bit of the result.
- R12: The zero flag is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | DATA_W (16) | Accumulator operand |
| opb_i | input | DATA_W (16) | Buffer-register operand |
| func_i | input | 4 | Function code |
| result_o | output | DATA_W (16) | Result word |
| sign_o | output | 1 | Most significant bit of the result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
Hand-picked operand pairs cover the edges of each function:
- Wrap-around in add and in subtract.
- Operands with the sign bit set, where a signed implementation would give a different answer from the unsigned one.
- Products that overflow the word, where a wrong slice of the product would show.
- Divisors of one and of zero, and a dividend smaller than its divisor.

For inversion and the shifts, the idle operand is swept while the used one is held fixed, so a unit that reads the wrong operand gives a different result. A pseudo-random sweep then runs every one of the sixteen codes. Random unused codes show that the accumulator passes through unchanged. Random results on either side of the sign and zero boundaries show whether the flags follow the result or some other signal.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_PASS = 4'h0,
      FN_ADD  = 4'h1,
      FN_SUB  = 4'h2,
      FN_AND  = 4'h3,
      FN_OR   = 4'h4,
      FN_NOT  = 4'h5,
      FN_SHR  = 4'h6,
      FN_SHL  = 4'h7,
      FN_MPY  = 4'h8,
      FN_DIV  = 4'h9
   } fn_e;

   typedef enum logic [1:0] {
      GRP_PASS  = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_LOGIC = 2'd2,
      GRP_MULDV = 2'd3
   } grp_e;

   function automatic grp_e fn_group(input logic [FUNC_W-1:0] code);
      case (code)
         FN_ADD, FN_SUB:                        fn_group = GRP_ARITH;
         FN_AND, FN_OR, FN_NOT, FN_SHR, FN_SHL: fn_group = GRP_LOGIC;
         FN_MPY, FN_DIV:                        fn_group = GRP_MULDV;
         default:                               fn_group = GRP_PASS;
      endcase
   endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o
);

   logic [DATA_W-1:0] b_eff;

   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, sub_i})) begin
         // R2
         sub_undo_chk: assert (!sub_i || ((sum_o + b_i) == a_i))
            else $error("subtract result does not restore the minuend");
         // R1
         add_undo_chk: assert (sub_i || ((sum_o - b_i) == a_i))
            else $error("add result does not restore the first operand");
      end
   end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic import acc_alu_pkg::*; #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [FUNC_W-1:0] code_i,
   output logic [DATA_W-1:0] res_o
);

   always_comb begin
      case (code_i)
         FN_AND:  res_o = a_i & b_i;
         FN_OR:   res_o = a_i | b_i;
         FN_NOT:  res_o = ~b_i;
         FN_SHR:  res_o = {1'b0, a_i[DATA_W-1:1]};
         FN_SHL:  res_o = {a_i[DATA_W-2:0], 1'b0};
         default: res_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, code_i})) begin
         // R5
         shr_fill_chk: assert (code_i != FN_SHR || ((res_o << 1) == (a_i & ~DATA_W'(1))))
            else $error("right shift lost bits or filled wrongly");
         // R6
         shl_fill_chk: assert (code_i != FN_SHL || ((res_o >> 1) == (a_i & ~(DATA_W'(1) << (DATA_W-1)))))
            else $error("left shift lost bits or filled wrongly");
         // R4
         not_cover_chk: assert (code_i != FN_NOT || (((res_o & b_i) == '0) && ((res_o | b_i) == '1)))
            else $error("inverse does not complement the buffer operand");
      end
   end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
   parameter int DATA_W    = 16,
   parameter int MUL_STYLE = 0,
   parameter int DIV_STYLE = 1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] prod_o,
   output logic [DATA_W-1:0] quot_o
);

   localparam int WIDE_W = 2 * DATA_W;

   generate
      if (MUL_STYLE == 0) begin : g_mul_native
         always_comb prod_o = a_i * b_i;
      end else begin : g_mul_array
         always_comb begin
            prod_o = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (b_i[i]) prod_o = prod_o + (a_i << i);
            end
         end
      end

      if (DIV_STYLE == 0) begin : g_div_native
         always_comb quot_o = (b_i == '0) ? '1 : (a_i / b_i);
      end else begin : g_div_restore
         logic [DATA_W:0] rem;
         logic [DATA_W:0] trial;
         always_comb begin
            rem    = '0;
            trial  = '0;
            quot_o = '0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
               trial = {rem[DATA_W-1:0], a_i[i]};
               if (trial >= {1'b0, b_i}) begin
                  rem       = trial - {1'b0, b_i};
                  quot_o[i] = 1'b1;
               end else begin
                  rem = trial;
               end
            end
         end
      end
   endgenerate

   logic [WIDE_W-1:0] q_wide, b_wide, a_wide;

   always_comb begin
      q_wide = {{DATA_W{1'b0}}, quot_o};
      b_wide = {{DATA_W{1'b0}}, b_i};
      a_wide = {{DATA_W{1'b0}}, a_i};
      if (!$isunknown({a_i, b_i})) begin
         // R9
         div_zero_chk: assert (b_i != '0 || quot_o == '1)
            else $error("zero divisor did not give all ones");
         // R8
         div_floor_chk: assert (b_i == '0 ||
                                ((q_wide * b_wide) <= a_wide && ((q_wide + 1) * b_wide) > a_wide))
            else $error("quotient is not the truncated value");
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu import acc_alu_pkg::*; #(
   parameter int DATA_W    = 16,
   parameter int MUL_STYLE = 0,
   parameter int DIV_STYLE = 1
) (
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [FUNC_W-1:0] func_i,
   output logic [DATA_W-1:0] result_o,
   output logic              sign_o,
   output logic              zero_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_mul
         $error("MUL_STYLE must be 0 or 1");
      end
      if (DIV_STYLE < 0 || DIV_STYLE > 1) begin : g_bad_div
         $error("DIV_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] arith_res, logic_res, prod_res, quot_res;
   grp_e              grp;

   acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (acc_i),
      .b_i   (opb_i),
      .sub_i (func_i == FN_SUB),
      .sum_o (arith_res)
   );

   acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i    (acc_i),
      .b_i    (opb_i),
      .code_i (func_i),
      .res_o  (logic_res)
   );

   acc_alu_muldiv #(
      .DATA_W    (DATA_W),
      .MUL_STYLE (MUL_STYLE),
      .DIV_STYLE (DIV_STYLE)
   ) u_muldiv (
      .a_i    (acc_i),
      .b_i    (opb_i),
      .prod_o (prod_res),
      .quot_o (quot_res)
   );

   always_comb begin
      grp = fn_group(func_i);
      case (grp)
         GRP_ARITH: result_o = arith_res;
         GRP_LOGIC: result_o = logic_res;
         GRP_MULDV: result_o = (func_i == FN_DIV) ? quot_res : prod_res;
         default:   result_o = acc_i;
      endcase
      sign_o = result_o[DATA_W-1];
      zero_o = ~|result_o;
   end

   always_comb begin
      if (!$isunknown({acc_i, opb_i, func_i})) begin
         // R11
         flag_excl_chk: assert (!(zero_o && sign_o))
            else $error("zero and sign flags both high");
         // R12
         zero_low_chk: assert (zero_o || (result_o != '0))
            else $error("zero flag low on an all-zero result");
         // R3
         and_bound_chk: assert (func_i != FN_AND || ((result_o | acc_i) == acc_i && (result_o | opb_i) == opb_i))
            else $error("AND result has a bit absent from an operand");
      end
   end

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

   localparam int DW = 16;

   typedef struct {
      logic [3:0]    fn;
      logic [DW-1:0] res;
      logic          sgn;
      logic          zro;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] acc, opb;
   logic [3:0]    fn;
   logic [DW-1:0] result;
   logic          sign, zero;
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;
   exp_t          sb[$];

   always #5 clk = ~clk;

   acc_alu u_acc_alu (
      .acc_i    (acc),
      .opb_i    (opb),
      .func_i   (fn),
      .result_o (result),
      .sign_o   (sign),
      .zero_o   (zero)
   );

   function automatic logic [DW-1:0] model(input logic [3:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [2*DW-1:0] p;
      case (f)
         4'h1: model = a + b;
         4'h2: model = a - b;
         4'h3: model = a & b;
         4'h4: model = a | b;
         4'h5: model = ~b;
         4'h6: model = a >> 1;
         4'h7: model = a << 1;
         4'h8: begin p = {16'h0, a} * {16'h0, b}; model = p[DW-1:0]; end
         4'h9: model = (b == 0) ? 16'hFFFF : a / b;
         default: model = a;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] f);
      case (f)
         4'h1: tag_of = "R1";
         4'h2: tag_of = "R2";
         4'h3, 4'h4: tag_of = "R3";
         4'h5: tag_of = "R4";
         4'h6: tag_of = "R5";
         4'h7: tag_of = "R6";
         4'h8: tag_of = "R7";
         4'h9: tag_of = "R8";
         default: tag_of = "R10";
      endcase
   endfunction

   task automatic drive(input logic [3:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      fn  = f;
      acc = a;
      opb = b;
      e.fn  = f;
      e.res = model(f, a, b);
      e.sgn = e.res[DW-1];
      e.zro = (e.res == 0);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: results are combinational, sampled at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (result !== e.res) begin
               n_bad++;
               $display("FAIL %s code=%h result got %h exp %h", e.tag, e.fn, result, e.res);
            end
            n_cmp++;
            if (sign !== e.sgn) begin
               n_bad++;
               $display("FAIL R11 (%s) code=%h sign got %b exp %b", e.tag, e.fn, sign, e.sgn);
            end
            n_cmp++;
            if (zero !== e.zro) begin
               n_bad++;
               $display("FAIL R12 (%s) code=%h zero got %b exp %b", e.tag, e.fn, zero, e.zro);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired got hung exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] s;
      fn  = 4'h0;
      acc = '0;
      opb = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // idle state after reset: pass code with zero operands, R10 R12
      drive(4'h0, 16'h0000, 16'h0000, "R10 reset");
      // R1 wrap-around and sign
      drive(4'h1, 16'hFFFF, 16'h0001, "R1 wrap");
      drive(4'h1, 16'h7FFF, 16'h0001, "R1 R11 into sign");
      drive(4'h1, 16'h1234, 16'h4321, "R1");
      // R2 borrow
      drive(4'h2, 16'h0000, 16'h0001, "R2 borrow");
      drive(4'h2, 16'h5555, 16'h5555, "R2 R12 equal");
      drive(4'h2, 16'h8000, 16'h0001, "R2");
      // R3
      drive(4'h3, 16'hF0F0, 16'hFF00, "R3 and");
      drive(4'h4, 16'hF0F0, 16'h0F0F, "R3 or");
      drive(4'h3, 16'hAAAA, 16'h5555, "R3 R12 disjoint");
      // R4 accumulator swept, buffer fixed
      drive(4'h5, 16'h0000, 16'h00FF, "R4 acc0");
      drive(4'h5, 16'hFFFF, 16'h00FF, "R4 acc1");
      drive(4'h5, 16'h1357, 16'hFFFF, "R4 R12");
      // R5 / R6 buffer swept, accumulator fixed
      drive(4'h6, 16'h8001, 16'h0000, "R5 msb fill");
      drive(4'h6, 16'h8001, 16'hFFFF, "R5 buffer ignored");
      drive(4'h6, 16'h0001, 16'h1234, "R5 R12 out");
      drive(4'h7, 16'h8001, 16'h0000, "R6 lsb fill");
      drive(4'h7, 16'h8001, 16'hFFFF, "R6 buffer ignored");
      drive(4'h7, 16'h4000, 16'h0000, "R6 R11 into sign");
      // R7 overflowing products
      drive(4'h8, 16'h000C, 16'h0003, "R7 small");
      drive(4'h8, 16'h0100, 16'h0100, "R7 R12 low half zero");
      drive(4'h8, 16'hFFFF, 16'hFFFF, "R7 full");
      drive(4'h8, 16'h1234, 16'h0567, "R7");
      // R8 / R9
      drive(4'h9, 16'h000C, 16'h0003, "R8 exact");
      drive(4'h9, 16'h0064, 16'h0007, "R8 truncate");
      drive(4'h9, 16'h8000, 16'h0001, "R8 unsigned msb");
      drive(4'h9, 16'h0003, 16'h0009, "R8 R12 small dividend");
      drive(4'h9, 16'hFFFF, 16'h8000, "R8");
      drive(4'h9, 16'h1234, 16'h0000, "R9 zero divisor");
      drive(4'h9, 16'h0000, 16'h0000, "R9 zero by zero");
      // R10 every unused code
      for (int c = 10; c < 16; c++) drive(4'(c), 16'hBEEF, 16'h1111, "R10 unused");
      // pseudo-random sweep of all codes
      s = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         logic [DW-1:0] a, b;
         s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
         a = s;
         s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
         b = (k % 7 == 0) ? {12'h0, s[3:0]} : s;
         drive(4'(k % 16), a, b, tag_of(4'(k % 16)));
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule